// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Width Select

This block turns a recovered serial stream of 8b/10b line characters into parallel words. A bit-enable strobe qualifies each incoming bit. A select input chooses between the normal serial input and a loopback serial input. Every arriving bit shifts into a sliding 10-bit window, so the block sees a fresh window at every bit position.

The block searches that window for the positive-disparity comma. When it finds one, it moves its character and word boundary so that the comma becomes the first character of a new word. Any partly assembled word is dropped, and no misaligned word is ever emitted. A width-select input picks one of two bus layouts:

- A 20-bit word made of two characters.
- A single 10-bit character in the upper half of the bus, with the lower half held high.

A one-cycle word strobe qualifies each word. A sync flag marks the word that holds a comma.

All outputs are registered. A word appears in the cycle after the bit-enable cycle that completes it. Word timing is given by the strobe; the block does not generate a separate word clock.

Top module: `comma_deser`

## Requirements
- R1: While synchronous reset is high and afterwards until the first word is emitted, wordData is all ones, wordValid is 0 and sync is 0.
- R2: With loopEn high, bits are taken from loopIn and serIn is ignored. With loopEn low, bits are taken from serIn and loopIn is ignored.
- R3: With widthSel low, each word holds two characters. The first character received goes to wordData[9:0] and the second to wordData[19:10]. Within each character, the earliest received bit sits at the lowest index, so the first bit of a word appears on wordData[0].
- R4: With widthSel high, each character is emitted as its own word on wordData[19:10], with its earliest bit on wordData[10]. In those words wordData[9:0] is 10'h3FF.
- R5: A comma is a 10-bit window whose earliest received bit is 0, followed by 0, then five 1s. The last three bits are not examined. The window is tested at every bit position, whatever the bit phase.
- R6: When a comma completes at a position that is not the current character boundary, the partial character and any pending first character are dropped. The comma becomes the first character of the next word, and bit counting restarts after it.
- R7: When sync detection is enabled, the word that holds a comma is emitted with sync high for exactly that one word. The comma sits on wordData[9:0] in 20-bit mode and on wordData[19:10] in 10-bit mode.
- R8: syncEn is sampled in the bit cycle in which the comma completes. When it is low, sync stays low, but realignment still takes place.
- R9: A comma that already starts on a character boundary causes no extra shift of that boundary. It still raises sync when sync detection is enabled.
- R10: In a cycle where widthSel rises, the bit and character counters are cleared and bitEn is ignored. The next accepted bit starts a new character and a new word.
- R11: wordValid is high for exactly one cycle per emitted word. Between strobes, wordData and sync hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bitEn | input | 1 | Qualifies one serial bit in this cycle |
| serIn | input | 1 | Normal serial data input |
| loopIn | input | 1 | Loopback serial data input |
| loopEn | input | 1 | Selects loopIn when high |
| syncEn | input | 1 | Enables the sync flag |
| widthSel | input | 1 | 0 selects the 20-bit bus, 1 selects the 10-bit bus; a rising edge clears the counters |
| wordData | output | 20 | Parallel word |
| wordValid | output | 1 | One-cycle strobe for each new word |
| sync | output | 1 | Marks the word that holds a comma |

## Verification
The bench places commas at every bit phase relative to the running boundary.

- **Realignment.** A design that failed to realign would emit words split across the comma.
- **Dropping the partial word.** A design that kept the partial first character would strobe a word ten bits too early.
- **Aligned commas.** Commas that already fall on a character boundary, in either slot of a 20-bit word, must raise sync without shifting the boundary. A design that always re-counted would mis-place the comma relative to the expected lane.
- **Mode and edge cases.** The bench also covers:
  - syncEn dropped while realignment continues;
  - a widthSel rising edge in the middle of a character, which must restart counting;
  - loopback selection with the unused input driven to the opposite value, so a wrong mux shows up as inverted data.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int CHAR_W = 10;
  localparam int LANES  = 2;

  typedef struct packed {
    logic shift;
    logic loadLow;
    logic emit;
    logic narrow;
    logic syncFlag;
  } deserStrobes_t;

  // Bit 0 is the earliest received bit of the window.
  function automatic logic isCommaChar(logic [CHAR_W-1:0] c);
    return (c[1:0] == 2'b00) && (c[6:2] == 5'b11111);
  endfunction
endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int CharW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bitEn,
  input  logic          commaHit,
  input  logic          widthSel,
  input  logic          syncEn,
  output deserStrobes_t strobes
);
  localparam int CntW = $clog2(CharW);
  localparam logic [CntW-1:0] LastBit = CntW'(CharW - 1);

  logic [CntW-1:0] bitCnt;
  logic charIdx;
  logic pendSync;
  logic widthQ;
  logic wSelRise;
  logic charDone;

  assign wSelRise = widthSel && !widthQ;

  always_comb begin
    strobes        = '0;
    strobes.narrow = widthSel;
    charDone       = 1'b0;
    if (bitEn && !wSelRise) begin
      strobes.shift = 1'b1;
      charDone      = commaHit || (bitCnt == LastBit);
      if (charDone) begin
        if (widthSel) begin
          strobes.emit     = 1'b1;
          strobes.syncFlag = commaHit && syncEn;
        end else if (commaHit || !charIdx) begin
          strobes.loadLow = 1'b1;
        end else begin
          strobes.emit     = 1'b1;
          strobes.syncFlag = pendSync;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      charIdx  <= 1'b0;
      pendSync <= 1'b0;
      widthQ   <= widthSel;
    end else begin
      widthQ <= widthSel;
      if (wSelRise) begin
        bitCnt   <= '0;
        charIdx  <= 1'b0;
        pendSync <= 1'b0;
      end else if (bitEn) begin
        bitCnt <= charDone ? '0 : bitCnt + 1'b1;
        if (charDone && !widthSel) begin
          if (commaHit || !charIdx) begin
            charIdx  <= 1'b1;
            pendSync <= commaHit && syncEn;
          end else begin
            charIdx  <= 1'b0;
          end
        end
      end
    end
  end

  // R10: counters restart on a width-select rising edge
  assert_width_reset_R10: assert property (@(posedge clk) disable iff (rst)
    wSelRise |=> (bitCnt == '0) && !charIdx);

  // R8: a narrow-mode sync flag requires sync detection enabled
  assert_sync_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.syncFlag && strobes.narrow) |-> syncEn);

  // R6: the bit counter never passes the character length
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LastBit);
endmodule

// File: rtl/deser_dpath.sv
module deser_dpath
  import deser_pkg::*;
#(
  parameter int CharW = CHAR_W,
  parameter int Lanes = LANES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     serIn,
  input  logic                     loopIn,
  input  logic                     loopEn,
  input  deserStrobes_t            strobes,
  output logic                     commaHit,
  output logic [Lanes*CharW-1:0]   wordData,
  output logic                     wordValid,
  output logic                     sync
);
  localparam int WordW = Lanes * CharW;

  logic [CharW-1:0] window;
  logic [CharW-1:0] nextWin;
  logic [CharW-1:0] lowChar;
  logic             rxBit;
  logic [WordW-1:0] wideWord;
  logic [WordW-1:0] narrowWord;

  assign rxBit    = loopEn ? loopIn : serIn;
  assign nextWin  = {rxBit, window[CharW-1:1]};
  assign commaHit = isCommaChar(nextWin);

  // Lane 0 holds the earlier character, the last lane holds the newest.
  for (genvar ln = 0; ln < Lanes; ln++) begin : g_lane
    if (ln == Lanes - 1) begin : g_top
      assign wideWord[ln*CharW +: CharW]   = nextWin;
      assign narrowWord[ln*CharW +: CharW] = nextWin;
    end else begin : g_low
      assign wideWord[ln*CharW +: CharW]   = lowChar;
      assign narrowWord[ln*CharW +: CharW] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      window    <= '1;
      lowChar   <= '1;
      wordData  <= '1;
      wordValid <= 1'b0;
      sync      <= 1'b0;
    end else begin
      wordValid <= strobes.emit;
      if (strobes.shift) window <= nextWin;
      if (strobes.loadLow) lowChar <= nextWin;
      if (strobes.emit) begin
        wordData <= strobes.narrow ? narrowWord : wideWord;
        sync     <= strobes.syncFlag;
      end
    end
  end

  // R4: unused lanes are all ones in narrow mode
  assert_narrow_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.emit && strobes.narrow) |=> (wordData[CharW-1:0] == '1));

  // R7: a flagged narrow word carries the comma in the top lane
  assert_sync_lane_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.emit && strobes.syncFlag && strobes.narrow)
      |=> isCommaChar(wordData[WordW-1 -: CharW]));

  // R7: a flagged wide word carries the comma in lane 0
  assert_sync_lane_lo_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.emit && strobes.syncFlag && !strobes.narrow)
      |=> isCommaChar(wordData[CharW-1:0]));

  // R11: outputs hold between strobes
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !strobes.emit |=> ($stable(wordData) && $stable(sync) && !wordValid));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import deser_pkg::*;
#(
  parameter int CharW = CHAR_W,
  parameter int Lanes = LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bitEn,
  input  logic                   serIn,
  input  logic                   loopIn,
  input  logic                   loopEn,
  input  logic                   syncEn,
  input  logic                   widthSel,
  output logic [Lanes*CharW-1:0] wordData,
  output logic                   wordValid,
  output logic                   sync
);
  deserStrobes_t strobes;
  logic commaHit;

  deser_ctrl #(.CharW(CharW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitEn    (bitEn),
    .commaHit (commaHit),
    .widthSel (widthSel),
    .syncEn   (syncEn),
    .strobes  (strobes)
  );

  deser_dpath #(.CharW(CharW), .Lanes(Lanes)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .loopIn    (loopIn),
    .loopEn    (loopEn),
    .strobes   (strobes),
    .commaHit  (commaHit),
    .wordData  (wordData),
    .wordValid (wordValid),
    .sync      (sync)
  );
endmodule

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  logic clk = 1'b0;
  logic rst, bitEn, serIn, loopIn, loopEn, syncEn, widthSel;
  logic [19:0] wordData;
  logic wordValid, sync;

  always #4 clk = ~clk;

  comma_deser dut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .serIn(serIn), .loopIn(loopIn),
    .loopEn(loopEn), .syncEn(syncEn), .widthSel(widthSel),
    .wordData(wordData), .wordValid(wordValid), .sync(sync)
  );

  int checks = 0;
  int fails  = 0;
  string curTag;

  // model state
  logic [9:0]  mWin;
  logic [3:0]  mCnt;
  logic        mIdx, mPend;
  logic [9:0]  mLow;
  logic [19:0] expData;
  logic        expSync;
  logic        modelWide;
  int          bitsSinceStrobe;

  localparam logic [9:0] COMMA = 10'b0101111100;

  function automatic logic commaOk(logic [9:0] w);
    return (w[0] == 1'b0) && (w[1] == 1'b0) && (w[6:2] == 5'b11111);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    mWin = '1; mCnt = 0; mIdx = 0; mPend = 0; mLow = '1;
    expData = '1; expSync = 0;
  endtask

  // Drives one bit at a negedge, checks outputs at the following negedge.
  task automatic sendBit(logic b);
    logic [9:0] w;
    logic cm, done, emit;
    if ($urandom_range(3) == 0) begin
      bitEn = 0;
      @(negedge clk);
      check({curTag, " R11 idle valid"}, wordValid, 0);
      check({curTag, " R11 idle hold"}, {sync, wordData}, {expSync, expData});
    end
    bitEn  = 1;
    serIn  = loopEn ? ~b : b;
    loopIn = loopEn ? b : ~b;
    w = {b, mWin[9:1]};
    cm = commaOk(w);
    done = cm || (mCnt == 9);
    mCnt = done ? 4'd0 : mCnt + 4'd1;
    emit = 0;
    if (done) begin
      if (widthSel) begin
        emit = 1; expData = {w, 10'h3FF}; expSync = cm && syncEn;
      end else if (cm || !mIdx) begin
        mLow = w; mIdx = 1; mPend = cm && syncEn;
      end else begin
        emit = 1; expData = {w, mLow}; expSync = mPend; mIdx = 0;
      end
    end
    mWin = w;
    @(negedge clk);
    bitEn = 0;
    bitsSinceStrobe++;
    check({curTag, " R11 valid"}, wordValid, emit);
    check({curTag, " data/sync"}, {sync, wordData}, {expSync, expData});
    if (emit) bitsSinceStrobe = 0;
  endtask

  task automatic sendChar(logic [9:0] c);
    for (int i = 0; i < 10; i++) sendBit(c[i]);
  endtask

  task automatic sendRandom(int n);
    for (int i = 0; i < n; i++) sendBit(1'($urandom_range(1)));
  endtask

  task automatic widthRise();
    bitEn = 0; widthSel = 0;
    @(negedge clk);
    widthSel = 1;
    bitEn = 1;           // must be ignored in the rising cycle (R10)
    serIn = 1'($urandom_range(1)); loopIn = serIn;
    @(negedge clk);
    bitEn = 0;
    mCnt = 0; mIdx = 0; mPend = 0;
    check("R10 no word on rise", wordValid, 0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; bitEn = 0; serIn = 0; loopIn = 0; loopEn = 0; syncEn = 1; widthSel = 0;
    resetModel();
    repeat (3) @(negedge clk);
    check("R1 reset data", wordData, 20'hFFFFF);
    check("R1 reset valid", wordValid, 0);
    check("R1 reset sync", sync, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {sync, wordValid, wordData}, {2'b00, 20'hFFFFF});

    // 20-bit mode, misaligned comma then aligned commas in both slots
    curTag = "R3 R5 R6";
    sendRandom(7);
    sendChar(COMMA);
    bitsSinceStrobe = 10;
    sendChar(10'h2A5);
    check("R6 strobe 20 bits after comma start", bitsSinceStrobe, 0);
    check("R7 sync on comma word", {sync, wordData[9:0]}, {1'b1, COMMA});
    curTag = "R9 R7";
    sendChar(COMMA); sendChar(10'h155);
    check("R9 aligned comma keeps boundary", {sync, wordData}, {1'b1, 10'h155, COMMA});
    sendChar(10'h0F3); sendChar(COMMA);  // comma in second slot: realigns
    sendChar(10'h333);
    check("R9 second-slot comma to lane 0", {sync, wordData[9:0]}, {1'b1, COMMA});
    curTag = "R3 random";
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(5) == 0) sendChar(COMMA);
      else sendChar(10'($urandom_range(1023)));
    end
    for (int p = 0; p < 10; p++) begin
      curTag = "R5 phase";
      sendRandom(p + 1);
      sendChar(COMMA);
      sendRandom(25);
    end

    // sync disabled
    curTag = "R8";
    syncEn = 0;
    sendRandom(4); sendChar(COMMA); sendChar(10'h1C7);
    check("R8 sync low, realigned", {sync, wordData}, {1'b0, 10'h1C7, COMMA});
    sendRandom(60);
    syncEn = 1;

    // 10-bit mode
    widthRise();
    curTag = "R4 R10";
    sendChar(10'h2D2);
    check("R10 R4 first char after rise", wordData, {10'h2D2, 10'h3FF});
    sendRandom(3); sendChar(COMMA);
    check("R4 R7 narrow comma", {sync, wordData}, {1'b1, COMMA, 10'h3FF});
    curTag = "R4 random";
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(4) == 0) sendRandom($urandom_range(1, 9));
      if ($urandom_range(4) == 0) sendChar(COMMA);
      else sendChar(10'($urandom_range(1023)));
    end

    // loopback
    loopEn = 1;
    curTag = "R2";
    sendRandom(2); sendChar(COMMA); sendChar(10'h0A9);
    check("R2 loopback data", wordData, {10'h0A9, 10'h3FF});
    sendRandom(80);
    loopEn = 0;
    curTag = "R2 normal";
    sendRandom(40);

    // width rise mid-character, back to 20-bit afterwards
    sendRandom(4);
    widthRise();
    curTag = "R10 mid";
    sendChar(10'h3C1);
    check("R10 restart mid char", wordData, {10'h3C1, 10'h3FF});
    widthSel = 0;
    @(negedge clk);
    curTag = "R10 wide";
    sendRandom(4); sendChar(COMMA); sendChar(10'h111);
    check("R3 wide after mode change", wordData, {10'h111, COMMA});
    sendRandom(200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule